// File: doc/BRIEF.md
# Burst-Fire Zero-Crossing Triac Sequencer

This block decides, one whole mains cycle at a time, whether a resistive heater load gets power through a triac. Every rising zero crossing advances an 11-bit cycle counter. The counter forms a slow digital sawtooth whose full sweep lasts exactly 2048 line periods. The top four counter bits go out as a code to an external DAC, which adds a staircase to the reference of an external analog comparator. The comparator answers on `cmp_demand`: high means the sensed voltage is below the reference, sawtooth included.

The comparator answer is not used on every cycle. It is latched once every 16 mains periods, at a rising crossing, and that decision is then held. Each period the latched decision allows is delivered as two gate pulses: one in the sync window that follows the rising crossing and one in the sync window that follows the falling crossing. The delivered pulse count therefore stays even. The gate output follows the externally timed sync window. A sensor-fault input removes it at once, in the same clock cycle.

The zero-crossing inputs are square signals from the mains detector. Each one passes through a two-flop synchroniser, and its rising edge becomes a one-clock strobe.

Top module: `burst_fire_seq`

## Requirements
- R1: After reset, `dac_code`, `gate_en` and `cycle_fired` are 0. No gate pulse appears before the first decision sample, which is taken at the 16th rising crossing.
- R2: The counter advances by one for each rising crossing. `dac_code` equals counter bits [10:7] and wraps to 0 after 2048 crossings.
- R3: The decision is latched from `cmp_demand` only at a rising crossing where counter bits [3:0] are all ones, just before they wrap to zero. It is held for the next 16 periods, whatever `cmp_demand` does in between.
- R4: In a period the decision allows, `gate_en` is granted in exactly two windows: the first sync window after the rising-crossing strobe and the first sync window after the falling-crossing strobe. `cycle_fired` pulses for one clock after the second window closes.
- R5: `gate_en` is high only while `sync_window` is high.
- R6: While `failsafe` is high, `gate_en` is low, starting in the same clock cycle.
- R7: If `failsafe` rises after the first pulse of a pair, the second pulse is suppressed and `cycle_fired` stays low, even if `failsafe` has already fallen again before the second window.
- R8: Without a fault, the total number of delivered gate windows is even.
- R9: A rising edge on `zc_rise` updates the counter at the third clock edge after it is applied, because it passes through two synchroniser flops and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_rise | input | 1 | Asynchronous level, high during the positive half-cycle |
| zc_fall | input | 1 | Asynchronous level, high during the negative half-cycle |
| sync_window | input | 1 | Pulse window from the external timing stage, synchronous to `clk` |
| cmp_demand | input | 1 | Comparator result; high means the sense voltage is below the reference |
| failsafe | input | 1 | Open-sensor fault; blocks all pulses |
| dac_code | output | 4 | Top sawtooth bits for the external DAC |
| gate_en | output | 1 | Triac gate enable |
| cycle_fired | output | 1 | One-clock strobe when a full pair has been delivered |

## Verification
The bench drives full mains periods in which the comparator demand is held steady, and also periods in which it changes between sample points. This separates a decision that is latched every 16 periods from one that is followed live. Fault patterns are applied at three moments: across a whole period, between the two pulses, and inside an open window. These distinguish an immediate block from one that waits for a registered state, and show that a split pair is never counted as fired. A run past 2048 periods checks the DAC staircase at every step, its wrap, and the exact synchroniser latency at each code change.

// File: rtl/burst_fire_pkg.sv
package burst_fire_pkg;

  // Events reported by the datapath to the control
  typedef struct packed {
    logic rise;       // rising-crossing strobe
    logic fall;       // falling-crossing strobe
    logic syncFall;   // sync window just closed
    logic sampleDue;  // this rise is a decision sample point
    logic fireDec;    // latched decision
    logic sampled;    // at least one decision taken since reset
  } dpEvt_t;

  // Strobes and levels sent by the control to the datapath
  typedef struct packed {
    logic takeSample;
    logic gateArmed;
    logic firedPulse;
  } ctlStb_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_GAP    = 2'd2,
    PH_SECOND = 2'd3
  } pairPhase_t;

endpackage

// File: rtl/zc_edge_sync.sv
module zc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic riseStb
);
  logic [STAGES-1:0] chain;
  logic lastLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= asyncIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lastLvl <= 1'b0;
    else        lastLvl <= chain[STAGES-1];

  assign riseStb = chain[STAGES-1] & ~lastLvl;
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import burst_fire_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int CODE_W      = 4,
  parameter int SLOT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zcRise,
  input  logic              zcFall,
  input  logic              syncWindow,
  input  logic              cmpDemand,
  input  logic              failsafe,
  input  ctlStb_t           ctl,
  output dpEvt_t            evt,
  output logic [CODE_W-1:0] dacCode,
  output logic              gateEn,
  output logic              cycleFired
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = {SLOT_W{1'b1}};

  logic riseStb, fallStb;
  logic [CNT_W-1:0] cycleCnt;
  logic fireDec, sampled, syncPrev;

  zc_edge_sync #(.STAGES(SYNC_STAGES)) u_rise_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(zcRise), .riseStb(riseStb));
  zc_edge_sync #(.STAGES(SYNC_STAGES)) u_fall_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(zcFall), .riseStb(fallStb));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cycleCnt <= '0;
    else if (riseStb) cycleCnt <= cycleCnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fireDec <= 1'b0;
      sampled <= 1'b0;
    end else if (ctl.takeSample) begin
      fireDec <= cmpDemand;
      sampled <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      syncPrev   <= 1'b0;
      cycleFired <= 1'b0;
    end else begin
      syncPrev   <= syncWindow;
      cycleFired <= ctl.firedPulse;
    end

  assign evt.rise      = riseStb;
  assign evt.fall      = fallStb;
  assign evt.syncFall  = syncPrev & ~syncWindow;
  assign evt.sampleDue = riseStb & (cycleCnt[SLOT_W-1:0] == SLOT_LAST);
  assign evt.fireDec   = fireDec;
  assign evt.sampled   = sampled;

  assign dacCode = cycleCnt[CNT_W-1 -: CODE_W];
  assign gateEn  = ctl.gateArmed & syncWindow & ~failsafe;
endmodule

// File: rtl/bf_control.sv
module bf_control
  import burst_fire_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dpEvt_t  evt,
  input  logic    cmpDemand,
  input  logic    failsafe,
  output ctlStb_t ctl
);
  pairPhase_t phase, phaseNxt;
  logic decision, eligible, fired;

  assign decision = evt.sampleDue ? cmpDemand : evt.fireDec;
  assign eligible = (evt.sampled | evt.sampleDue) & decision & ~failsafe;

  always_comb begin
    phaseNxt = phase;
    fired    = 1'b0;
    case (phase)
      PH_FIRST:  if (evt.syncFall) phaseNxt = PH_GAP;
      PH_GAP:    if (evt.fall)     phaseNxt = PH_SECOND;
      PH_SECOND: if (evt.syncFall) begin
                   phaseNxt = PH_IDLE;
                   fired    = 1'b1;
                 end
      default:   phaseNxt = PH_IDLE;
    endcase
    if (evt.rise) phaseNxt = eligible ? PH_FIRST : PH_IDLE;
    if (failsafe) begin
      phaseNxt = PH_IDLE;
      fired    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNxt;

  assign ctl.takeSample = evt.sampleDue;
  assign ctl.gateArmed  = (phase == PH_FIRST) | (phase == PH_SECOND);
  assign ctl.firedPulse = fired;
endmodule

// File: rtl/burst_fire_seq.sv
module burst_fire_seq
  import burst_fire_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int CODE_W      = 4,
  parameter int SLOT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_rise,
  input  logic              zc_fall,
  input  logic              sync_window,
  input  logic              cmp_demand,
  input  logic              failsafe,
  output logic [CODE_W-1:0] dac_code,
  output logic              gate_en,
  output logic              cycle_fired
);
  dpEvt_t  evt;
  ctlStb_t ctl;

  bf_datapath #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .SLOT_W(SLOT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .zcRise(zc_rise), .zcFall(zc_fall),
    .syncWindow(sync_window), .cmpDemand(cmp_demand), .failsafe(failsafe),
    .ctl(ctl), .evt(evt), .dacCode(dac_code), .gateEn(gate_en),
    .cycleFired(cycle_fired));

  bf_control u_ctl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cmpDemand(cmp_demand),
    .failsafe(failsafe), .ctl(ctl));
endmodule

// File: rtl/burst_fire_chk.sv
module burst_fire_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_window,
  input logic              failsafe,
  input logic              gate_en,
  input logic              cycle_fired,
  input logic [CODE_W-1:0] dac_code
);
  p_gate_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> sync_window);

  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe |-> !gate_en);

  p_code_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> (dac_code == CODE_W'($past(dac_code) + 1'b1)));

  p_fired_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_fired |=> !cycle_fired);

  p_fired_after_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_fired |-> (!$past(sync_window) && $past(sync_window, 2)));
endmodule

bind burst_fire_seq burst_fire_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_window(sync_window), .failsafe(failsafe),
  .gate_en(gate_en), .cycle_fired(cycle_fired), .dac_code(dac_code));

// File: tb/burst_fire_seq_tb.sv
module burst_fire_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_LEN    = 3;

  logic clk = 1'b0;
  logic rst_n, zc_rise, zc_fall, sync_window, cmp_demand, failsafe;
  logic [3:0] dac_code;
  logic gate_en, cycle_fired;

  int checks = 0, failures = 0;
  int mcnt = 0;        // rising crossings since reset
  bit mdec = 0, msampled = 0;
  int evenTotal = 0;   // windows delivered in fault-free periods

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_fire_seq u_dut (
    .clk(clk), .rst_n(rst_n), .zc_rise(zc_rise), .zc_fall(zc_fall),
    .sync_window(sync_window), .cmp_demand(cmp_demand), .failsafe(failsafe),
    .dac_code(dac_code), .gate_en(gate_en), .cycle_fired(cycle_fired));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One mains period. fsMode: 0 none, 1 fault whole period,
  // 2 fault between the pulses, 3 fault inside the first window.
  task automatic mains_cycle(input bit demand, input int fsMode, input string req);
    int ga = 0, gb = 0, fired = 0, outside = 0;
    int codeBefore, codeAfter, expA, expB, expF;
    bit expFire;
    codeBefore = (mcnt >> 7) % 16;
    codeAfter  = ((mcnt + 1) >> 7) % 16;
    if (mcnt % 16 == 15) begin mdec = demand; msampled = 1; end
    expFire = msampled && mdec && (fsMode != 1);
    mcnt++;

    @(negedge clk);
    cmp_demand = demand;
    if (fsMode == 1) failsafe = 1'b1;
    @(negedge clk);
    zc_rise = 1'b1; zc_fall = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); #1;
      if (k == 2 && codeBefore != codeAfter)
        chk(dac_code == 4'(codeBefore), "R9", "code before third edge", dac_code, codeBefore);
      if (k == 3)
        chk(dac_code == 4'(codeAfter), "R2", "dac code", dac_code, codeAfter);
      if (gate_en) outside++;
    end
    for (int k = 0; k < WIN_LEN; k++) begin
      @(negedge clk);
      sync_window = 1'b1;
      if (fsMode == 3 && k == 1) failsafe = 1'b1;
      #1; if (gate_en) ga++;
    end
    @(negedge clk); sync_window = 1'b0; #1; if (gate_en) outside++;
    if (fsMode == 2) failsafe = 1'b1;
    repeat (2) @(negedge clk);
    if (fsMode == 2) failsafe = 1'b0;   // fault clears before second window
    zc_rise = 1'b0; zc_fall = 1'b1;
    for (int k = 1; k <= 4; k++) begin @(negedge clk); #1; if (gate_en) outside++; end
    for (int k = 0; k < WIN_LEN; k++) begin
      @(negedge clk); sync_window = 1'b1; #1; if (gate_en) gb++;
    end
    @(negedge clk); sync_window = 1'b0; #1; if (gate_en) outside++;
    for (int k = 0; k < 3; k++) begin @(negedge clk); #1; if (cycle_fired) fired++; end
    zc_fall = 1'b0; failsafe = 1'b0;

    expA = !expFire ? 0 : (fsMode == 3 ? 1 : WIN_LEN);
    expB = (expFire && fsMode == 0) ? WIN_LEN : 0;
    expF = (expFire && fsMode == 0) ? 1 : 0;
    chk(ga == expA, req, "first window gate clocks", ga, expA);
    chk(gb == expB, req, "second window gate clocks", gb, expB);
    chk(fired == expF, req, "cycle_fired pulses", fired, expF);
    chk(outside == 0, "R5", "gate outside window", outside, 0);
    if (fsMode == 0 || fsMode == 1)
      evenTotal += (ga == WIN_LEN ? 1 : 0) + (gb == WIN_LEN ? 1 : 0);
  endtask

  task automatic t_reset();
    #1;
    chk(dac_code == 4'd0, "R1", "dac after reset", dac_code, 0);
    chk(gate_en == 1'b0, "R1", "gate after reset", gate_en, 0);
    chk(cycle_fired == 1'b0, "R1", "fired after reset", cycle_fired, 0);
  endtask

  task automatic t_first_sample();
    for (int i = 0; i < 15; i++) mains_cycle(1'b1, 0, "R1");   // no sample yet
    mains_cycle(1'b1, 0, "R3");                                 // first sample: fires
    chk(msampled == 1, "R1", "model sampled", msampled, 1);
  endtask

  task automatic t_hold();
    mains_cycle(1'b0, 0, "R3");                                 // still held high
    for (int i = 0; i < 14; i++) mains_cycle(i[0], 0, "R3");
    mains_cycle(1'b0, 0, "R3");                                 // sample low
    mains_cycle(1'b1, 0, "R3");                                 // held low
    for (int i = 0; i < 14; i++) mains_cycle(1'b1, 0, "R4");
    mains_cycle(1'b1, 0, "R4");                                 // sample high
  endtask

  task automatic t_failsafe();
    mains_cycle(1'b1, 1, "R6");
    mains_cycle(1'b1, 2, "R7");
    mains_cycle(1'b1, 3, "R6");
    mains_cycle(1'b1, 0, "R4");
  endtask

  task automatic t_dac_sweep();
    while (mcnt < 2048 + 20) mains_cycle(((mcnt >> 4) % 3) != 0, 0, "R4");
    chk(dac_code == 4'(((mcnt >> 7) % 16)), "R2", "dac after wrap", dac_code, (mcnt >> 7) % 16);
    chk(evenTotal % 2 == 0, "R8", "even pulse total parity", evenTotal % 2, 0);
  endtask

  initial begin
    rst_n = 1'b0; zc_rise = 1'b0; zc_fall = 1'b0; sync_window = 1'b0;
    cmp_demand = 1'b0; failsafe = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_sample();
    t_hold();
    t_failsafe();
    t_dac_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule